// File: doc/BRIEF.md
# Power-up SPI configuration loader

This block programs an external clock-synthesizer chip over SPI as soon as the chip's system reset is released. A constant table of sixteen 32-bit words is held on chip. In each word, bits 31..4 carry the register contents and bits 3..0 name the destination register. The loader reads the table from entry 0 upward and sends each whole word as one 32-bit SPI frame, most significant bit first. It finishes when it has sent the word whose register field matches a terminal register number (0xC by default). For this reason the word for that register must be the last one the table needs to deliver.

The default table fills entries 0 to 12 with the settings for registers 0x0 to 0xC in ascending order, and leaves entries 13 to 15 at zero. If no word carries the terminal register number, the pass ends after entry 15 and an error flag is set beside done. A single-cycle start pulse repeats the pass from entry 0, for example after the synthesizer has been reset on its own. SCLK is the system clock divided by the even parameter DIV.

Top module: `spi_cfg_loader`

## Requirements
- R1: During reset cs_n is 1, sclk is 0, done is 0 and err is 0. In the first cycle after reset is released, the block is busy and cs_n is low, sending entry 0.
- R2: Each frame has exactly 32 bits, sent most significant bit first, and its content equals the table word unchanged (bits 31..4 data, bits 3..0 register number).
- R3: Frames follow ascending table order. The pass ends with the first word whose bits 3..0 equal the terminal number (0xC by default), and no later entry is ever sent. With the default table this gives 13 frames.
- R4: cs_n stays low for exactly 32*DIV system clocks per frame and encloses exactly 32 SCLK rising edges. cs_n rises in the same cycle as the final SCLK fall.
- R5: One SCLK period is DIV system clocks, with DIV/2 high and DIV/2 low. SCLK is low whenever cs_n is high.
- R6: mosi changes only when SCLK falls or cs_n falls, so it holds steady for the whole time SCLK is high.
- R7: Between two frames, cs_n stays high for at least 2*DIV system clocks.
- R8: At the end of a pass, done goes to 1 and busy goes to 0. done then stays 1, with no further frames, until the next start pulse.
- R9: If none of the 16 entries carries the terminal number, exactly 16 frames are sent, and then done and err both go to 1.
- R10: When idle, a start pulse begins a new pass from entry 0 and clears done and err in the next cycle. A start pulse received while busy is ignored: the current pass continues in order and sends the same number of frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; its release begins a pass |
| start | input | 1 | Single-cycle request for a new pass |
| sclk | output | 1 | SPI serial clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI serial data out |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | The last pass has finished |
| err | output | 1 | The last pass found no terminal register |

## Verification
The hardest case to reach from the ports is the safety stop. The default table always contains the terminal word, so the stop after 16 entries can never happen through start or reset. To reach it, the bench runs a second instance with a faster divider and a terminal number that appears in no entry, and it expects 16 frames followed by err. A start pulse that arrives in the middle of a pass is the other case that is hard to observe. A single SPI slave model captures every frame and checks it against the expected entry index, so any restart shows up as an out-of-order word.

// File: rtl/cfg_loader_pkg.sv
// Package for the configuration loader: default table and state encodings.
// Assumes a table of 16 words of 32 bits; entries with no setting are zero.
package cfg_loader_pkg;

    localparam int DEF_ENTRIES = 16;
    localparam int DEF_WORD_W  = 32;

    // Entry 0 sits in the lowest 32 bits.
    localparam logic [DEF_ENTRIES*DEF_WORD_W-1:0] DEF_TABLE = {
        32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
        32'h0000_180C, 32'h0000_040B, 32'h05FC_270A, 32'h6805_0CC9,
        32'h6800_0098, 32'h8380_0017, 32'h6800_0006, 32'h6800_0005,
        32'hE980_0004, 32'h6800_0003, 32'h8304_0002, 32'h6800_0021,
        32'h683C_0350
    };

    typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_WAIT} seq_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP}  tx_state_t;

endpackage

// File: rtl/cfg_rom.sv
// Constant lookup table built from a packed parameter.
// Assumes ENTRIES is a power of two so the index covers every entry exactly.
module cfg_rom #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 32,
    parameter logic [ENTRIES*WORD_W-1:0] TABLE = '0,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic [IW-1:0]     idx,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] mem [ENTRIES];

    // Unpack each table slot into the array
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        assign mem[e] = TABLE[e*WORD_W +: WORD_W];
    end

    // Combinational read
    assign word = mem[idx];

endmodule

// File: rtl/spi_frame_tx.sv
// Sends one word as a single SPI frame in mode 0, MSB first. After the frame it
// keeps chip select high for a gap, then pulses tx_done.
// Assumes DIV is even and at least 2, and that go arrives only while idle.
module spi_frame_tx
    import cfg_loader_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int DIV      = 8,
    parameter int GAP_SCLK = 2,
    localparam int HALF    = DIV / 2,
    localparam int CW      = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int BW      = $clog2(WORD_W),
    localparam int GAP_CYC = GAP_SCLK * DIV,
    localparam int GW      = $clog2(GAP_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] word,
    output logic              tx_done,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi
);

    tx_state_t         st_q;
    logic [WORD_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [GW-1:0]     gap_q;

    // Frame engine: half-period timer, SCLK toggling, shifting, inter-frame gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= TX_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            bit_q   <= '0;
            gap_q   <= '0;
            sclk    <= 1'b0;
            cs_n    <= 1'b1;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            case (st_q)
                TX_IDLE: begin
                    if (go) begin
                        sh_q  <= word;
                        cs_n  <= 1'b0;
                        cnt_q <= '0;
                        bit_q <= '0;
                        st_q  <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (cnt_q == CW'(HALF - 1)) begin
                        cnt_q <= '0;
                        if (!sclk) begin
                            sclk <= 1'b1;
                        end else begin
                            sclk <= 1'b0;
                            if (bit_q == BW'(WORD_W - 1)) begin
                                cs_n  <= 1'b1;
                                gap_q <= '0;
                                st_q  <= TX_GAP;
                            end else begin
                                sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TX_GAP: begin
                    if (gap_q == GW'(GAP_CYC - 1)) begin
                        tx_done <= 1'b1;
                        st_q    <= TX_IDLE;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    // Serial data is the top bit of the shift register
    assign mosi = sh_q[WORD_W-1];

endmodule

// File: rtl/cfg_loader_seq.sv
// Walks the table index, starts one frame per entry and decides when the pass
// ends (terminal register sent, or last entry reached).
// Assumes tx_done comes exactly once for each go.
module cfg_loader_seq
    import cfg_loader_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] TERM_ADDR = 4'hC,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rom_addr,
    input  logic              tx_done,
    output logic [IW-1:0]     idx,
    output logic              go,
    output logic              busy,
    output logic              done,
    output logic              err
);

    seq_state_t        st_q;
    logic [ADDR_W-1:0] addr_q;

    // Pass control: fetch, wait for frame, then advance or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_FETCH;
            idx    <= '0;
            addr_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (start) begin
                        idx  <= '0;
                        done <= 1'b0;
                        err  <= 1'b0;
                        st_q <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    addr_q <= rom_addr;
                    st_q   <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (tx_done) begin
                        if (addr_q == TERM_ADDR) begin
                            done <= 1'b1;
                            st_q <= SQ_IDLE;
                        end else if (idx == IW'(ENTRIES - 1)) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                            st_q <= SQ_IDLE;
                        end else begin
                            idx  <= idx + 1'b1;
                            st_q <= SQ_FETCH;
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // One-cycle frame request and the activity flag
    assign go   = (st_q == SQ_FETCH);
    assign busy = (st_q != SQ_IDLE);

endmodule

// File: rtl/spi_cfg_loader.sv
// Top level: table, sequencer and SPI frame sender. Runs one pass after reset
// and one more for each start pulse received while idle.
// Assumes DIV is even and at least 2, and ENTRIES is a power of two.
module spi_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int ENTRIES  = DEF_ENTRIES,
    parameter int WORD_W   = DEF_WORD_W,
    parameter int ADDR_W   = 4,
    parameter int DIV      = 8,
    parameter int GAP_SCLK = 2,
    parameter logic [ADDR_W-1:0] TERM_ADDR = 4'hC,
    parameter logic [ENTRIES*WORD_W-1:0] TABLE = DEF_TABLE,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic sclk,
    output logic cs_n,
    output logic mosi,
    output logic busy,
    output logic done,
    output logic err
);

    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] word;
    logic              go;
    logic              tx_done;

    cfg_rom #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .TABLE(TABLE)) u_rom (
        .idx  (idx),
        .word (word)
    );

    cfg_loader_seq #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TERM_ADDR(TERM_ADDR)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rom_addr (word[ADDR_W-1:0]),
        .tx_done  (tx_done),
        .idx      (idx),
        .go       (go),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    spi_frame_tx #(.WORD_W(WORD_W), .DIV(DIV), .GAP_SCLK(GAP_SCLK)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .word    (word),
        .tx_done (tx_done),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi)
    );

endmodule

// File: rtl/spi_cfg_loader_chk.sv
// Protocol and status checks for spi_cfg_loader, attached with bind.
// Assumes a synchronous active-low reset.
module spi_cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy,
    input logic done,
    input logic err
);

    a_r5_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r4_cs_rise_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $fell(sclk));

    a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r1_select_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

bind spi_cfg_loader spi_cfg_loader_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .mosi  (mosi),
    .busy  (busy),
    .done  (done),
    .err   (err)
);

// File: tb/spi_cfg_loader_test.sv
// SPI slave model: rebuilds frames and checks timing at each negative clock edge.
module spi_cfg_loader_mon #(
    parameter int    DIV  = 8,
    parameter string NAME = "uut"
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        fv,
    output logic [31:0] fword,
    output int          nchk,
    output int          nfail
);
    logic        ps = 1'b0, pcs = 1'b1, pm = 1'b0, seen = 1'b0;
    logic [31:0] cap = '0;
    int          bitc = 0, lowc = 0, highc = 0, gapc = 0;

    initial begin
        nchk = 0; nfail = 0; fv = 1'b0; fword = '0;
    end

    always @(negedge clk) begin
        fv = 1'b0;
        if (rst_n) begin
            if (cs_n && sclk) begin
                nfail++;
                $display("FAIL R5 %s sclk high while idle: act=%0b exp=0", NAME, sclk);
            end
            if (sclk && ps) begin
                highc++;
                if (mosi !== pm) begin
                    nfail++;
                    $display("FAIL R6 %s mosi moved while sclk high: act=%0b exp=%0b", NAME, mosi, pm);
                end
            end
            if (sclk && !ps && !cs_n) begin
                cap = {cap[30:0], mosi};
                bitc++;
                highc = 1;
            end
            if (!sclk && ps) begin
                nchk++;
                if (highc != DIV/2) begin
                    nfail++;
                    $display("FAIL R5 %s sclk high cycles: act=%0d exp=%0d", NAME, highc, DIV/2);
                end
            end
            if (!cs_n && pcs) begin
                if (seen) begin
                    nchk++;
                    if (gapc < 2*DIV) begin
                        nfail++;
                        $display("FAIL R7 %s gap cycles: act=%0d exp>=%0d", NAME, gapc, 2*DIV);
                    end
                end
                lowc = 0; bitc = 0;
            end
            if (!cs_n) lowc++;
            if (cs_n && !pcs) begin
                nchk++;
                if (bitc != 32 || lowc != 32*DIV) begin
                    nfail++;
                    $display("FAIL R4 %s frame bits/cycles: act=%0d/%0d exp=32/%0d", NAME, bitc, lowc, 32*DIV);
                end
                fv = 1'b1; fword = cap; seen = 1'b1; gapc = 0;
            end
            if (cs_n) gapc++;
        end
        ps = sclk; pcs = cs_n; pm = mosi;
    end
endmodule

// Bench: default instance plus an instance with a terminal number that never matches.
module spi_cfg_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic start_b = 1'b0;
    always #5 clk = ~clk;

    logic sclk, cs_n, mosi, busy, done, err;
    logic sclk_b, cs_n_b, mosi_b, busy_b, done_b, err_b;

    spi_cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .busy(busy), .done(done), .err(err)
    );

    spi_cfg_loader #(.DIV(4), .TERM_ADDR(4'hD)) uut_noterm (
        .clk(clk), .rst_n(rst_n), .start(start_b), .sclk(sclk_b), .cs_n(cs_n_b),
        .mosi(mosi_b), .busy(busy_b), .done(done_b), .err(err_b)
    );

    logic        fv_a, fv_b;
    logic [31:0] fw_a, fw_b;
    int          mc_a, mf_a, mc_b, mf_b;

    spi_cfg_loader_mon #(.DIV(8), .NAME("uut")) mon_a (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .fv(fv_a), .fword(fw_a), .nchk(mc_a), .nfail(mf_a)
    );
    spi_cfg_loader_mon #(.DIV(4), .NAME("uut_noterm")) mon_b (
        .clk(clk), .rst_n(rst_n), .sclk(sclk_b), .cs_n(cs_n_b), .mosi(mosi_b),
        .fv(fv_b), .fword(fw_b), .nchk(mc_b), .nfail(mf_b)
    );

    logic [31:0] exp_tab [16] = '{
        32'h683C0350, 32'h68000021, 32'h83040002, 32'h68000003,
        32'hE9800004, 32'h68000005, 32'h68000006, 32'h83800017,
        32'h68000098, 32'h68050CC9, 32'h05FC270A, 32'h0000040B,
        32'h0000180C, 32'h00000000, 32'h00000000, 32'h00000000
    };

    int tests = 0, fails = 0, cyc = 0;
    int nfr_a = 0, nfr_b = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        tests += mc_a + mc_b;
        fails += mf_a + mf_b;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Reference model: each captured frame must equal the next expected entry (R2, R3)
    always @(negedge clk) begin
        cyc++;
        if (fv_a) begin
            check(nfr_a < 13 && fw_a == exp_tab[nfr_a % 16], "R2/R3 uut frame", fw_a, exp_tab[nfr_a % 16]);
            nfr_a++;
        end
        if (fv_b) begin
            check(nfr_b < 16 && fw_b == exp_tab[nfr_b % 16], "R2/R9 uut_noterm frame", fw_b, exp_tab[nfr_b % 16]);
            nfr_b++;
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wait_done_a();
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(cs_n == 1'b1 && sclk == 1'b0, "R1 reset pins", {30'd0, cs_n, sclk}, 32'h2);
        check(done == 1'b0 && err == 1'b0, "R1 reset flags", {30'd0, done, err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b1 && cs_n == 1'b0, "R1 pass starts", {30'd0, busy, cs_n}, 32'h2);

        // R10: start while busy is ignored
        repeat (1000) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done_a();
        check(nfr_a == 13, "R3 frame count", nfr_a, 13);
        check(busy == 1'b0 && err == 1'b0, "R8 end flags", {30'd0, busy, err}, 32'h0);

        // R8: done holds and nothing more is sent
        repeat (200) @(negedge clk);
        check(done == 1'b1, "R8 done held", {31'd0, done}, 32'h1);
        check(nfr_a == 13 && cs_n == 1'b1, "R3 no later entries", nfr_a, 13);

        // R10: restart from entry 0
        nfr_a = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && busy == 1'b1, "R10 restart clears", {30'd0, done, busy}, 32'h1);
        wait_done_a();
        check(nfr_a == 13 && err == 1'b0, "R10 second pass count", nfr_a, 13);

        // R9: no terminal found
        while (!done_b) @(negedge clk);
        check(nfr_b == 16, "R9 frame count", nfr_b, 16);
        check(err_b == 1'b1 && busy_b == 1'b0, "R9 err and done", {30'd0, err_b, busy_b}, 32'h2);
        repeat (100) @(negedge clk);
        check(nfr_b == 16 && done_b == 1'b1, "R9 stays stopped", nfr_b, 16);

        finish_run();
    end
endmodule